// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block listens to a keyboard on the two PS/2 lines, clock and data, and turns what it hears into key events in the system clock domain. It brings both lines through a synchroniser and filters the keyboard clock so that short glitches are rejected. It then samples the data line on each falling edge of the filtered clock and checks every 11-bit frame for framing and parity.

Good bytes go to a small decoder. The decoder holds the extended prefix (0xE0) and the release prefix (0xF0) as pending flags and does not emit them. It then gives one event for the code byte that follows. Each event is a one-cycle valid pulse that carries the 8-bit scan code, a released flag and an extended flag. A frame with a bad stop bit or bad parity produces no byte. It raises a one-cycle error pulse instead. If a frame stops partway, a timeout clears it, so the next frame is received cleanly.

Top module: `ps2_keyrx`

## Requirements
- R1: Data bits are taken on falling edges of the keyboard clock, least significant bit first. A frame carrying byte 0x81 reports code 0x81.
- R2: A frame is a 0 start bit, eight data bits, a parity bit and a stop bit. A stop bit of 0 drops the frame and pulses `frame_err_o` for one cycle, with no key event.
- R3: Parity is odd over the eight data bits plus the parity bit. A mismatch drops the frame and pulses `frame_err_o`, and no key event is emitted. A later good frame of the same byte is still received.
- R4: A code byte with no pending prefix gives one event with `key_rel_o`=0 and `key_ext_o`=0.
- R5: Byte 0xF0 gives no event. It makes the next code byte's event carry `key_rel_o`=1.
- R6: Byte 0xE0 gives no event. It makes the next code byte's event carry `key_ext_o`=1.
- R7: The sequence 0xE0, 0xF0, code gives exactly one event, with `key_rel_o`=1 and `key_ext_o`=1.
- R8: Both pending flags clear once a code event has been emitted. A following plain code has both flags at 0.
- R9: Two things add no bits to a frame: the keyboard clock held low for any time while idle, and a clock low pulse shorter than `FILT_LEN` system cycles. The next frame decodes correctly.
- R10: If no clock falling edge arrives for `TIMEOUT_CYC` system cycles during a frame, the partial frame is abandoned. The next complete frame decodes correctly.
- R11: While reset is held, `key_valid_o` and `frame_err_o` are 0.
- R12: `key_valid_o` is high for exactly one system cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ps2_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| ps2_dat_i | input | 1 | Keyboard data line (asynchronous) |
| key_valid_o | output | 1 | One-cycle pulse marking a key event |
| key_code_o | output | 8 | Scan code of the event |
| key_rel_o | output | 1 | 1 when the event is a key release |
| key_ext_o | output | 1 | 1 when the event is an extended key |
| frame_err_o | output | 1 | One-cycle pulse for a dropped frame (bad stop or parity) |

## Verification
The hardest states to reach are a frame abandoned partway and a clock glitch inside a frame. Both need the bench to break the serial waveform at a chosen bit. The driver task therefore takes a bit index at which it either stops clocking, for longer than the timeout, or inserts a two-cycle low pulse during the clock's high phase. The frame that follows is then checked through the scoreboard. Any miscount of bits would show up there as a wrong code or a spurious error.

// File: rtl/ps2_keyrx_pkg.sv
package ps2_keyrx_pkg;
  localparam int          FRAME_BITS = 11;
  localparam int          CNT_W      = $clog2(FRAME_BITS);
  localparam logic [7:0]  PFX_EXT    = 8'hE0;
  localparam logic [7:0]  PFX_REL    = 8'hF0;

  typedef struct packed {
    logic [7:0] code;
    logic       rel;
    logic       ext;
  } key_evt_t;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int FCNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] clk_sr_q, clk_sr_d;
  logic [SYNC_STAGES-1:0] dat_sr_q, dat_sr_d;
  logic [FCNT_W-1:0]      fcnt_q, fcnt_d;
  logic                   filt_q, filt_d;
  logic                   fall_q, fall_d;
  logic                   sclk;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        clk_sr_d = ps2_clk_i;
        dat_sr_d = ps2_dat_i;
      end
    end else begin : g_many
      always_comb begin
        clk_sr_d = {clk_sr_q[SYNC_STAGES-2:0], ps2_clk_i};
        dat_sr_d = {dat_sr_q[SYNC_STAGES-2:0], ps2_dat_i};
      end
    end
  endgenerate

  assign sclk = clk_sr_q[SYNC_STAGES-1];

  always_comb begin
    fcnt_d = '0;
    filt_d = filt_q;
    if (sclk != filt_q) begin
      if (fcnt_q == FCNT_W'(FILT_LEN - 1)) begin
        filt_d = sclk;
      end else begin
        fcnt_d = fcnt_q + 1'b1;
      end
    end
    fall_d = filt_q & ~filt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sr_q <= '1;
      dat_sr_q <= '1;
      fcnt_q   <= '0;
      filt_q   <= 1'b1;
      fall_q   <= 1'b0;
    end else begin
      clk_sr_q <= clk_sr_d;
      dat_sr_q <= dat_sr_d;
      fcnt_q   <= fcnt_d;
      filt_q   <= filt_d;
      fall_q   <= fall_d;
    end
  end

  assign fall_o = fall_q;
  assign dat_o  = dat_sr_q[SYNC_STAGES-1];

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q); // R9
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_keyrx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       err_o
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic             par_q, par_d;
  logic [TMO_W-1:0] idle_q, idle_d;
  logic             vld_q, vld_d;
  logic             err_q, err_d;
  logic             tmo;

  assign tmo = (cnt_q != '0) && (idle_q == TMO_W'(TIMEOUT_CYC - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    par_d  = par_q;
    idle_d = '0;
    vld_d  = 1'b0;
    err_d  = 1'b0;
    if (fall_i) begin
      if (cnt_q == '0) begin
        if (!dat_i) cnt_d = CNT_W'(1);
      end else if (cnt_q <= CNT_W'(8)) begin
        sh_d  = {dat_i, sh_q[7:1]};
        cnt_d = cnt_q + 1'b1;
      end else if (cnt_q == CNT_W'(9)) begin
        par_d = dat_i;
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        if (dat_i && (^{sh_q, par_q})) vld_d = 1'b1;
        else                           err_d = 1'b1;
      end
    end else if (tmo) begin
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      idle_d = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      idle_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      idle_q <= idle_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = sh_q;
  assign err_o      = err_q;

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_BITS - 1)); // R2
  AST_NO_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_i && !tmo) |=> $stable(cnt_q)); // R9
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && err_q)); // R3
endmodule

// File: rtl/ps2_key_decode.sv
module ps2_key_decode
  import ps2_keyrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       evt_vld_o,
  output key_evt_t   evt_o
);
  logic     ext_pend_q, ext_pend_d;
  logic     rel_pend_q, rel_pend_d;
  logic     vld_q, vld_d;
  key_evt_t evt_q, evt_d;

  always_comb begin
    ext_pend_d = ext_pend_q;
    rel_pend_d = rel_pend_q;
    vld_d      = 1'b0;
    evt_d      = evt_q;
    if (byte_vld_i) begin
      if (byte_i == PFX_EXT) begin
        ext_pend_d = 1'b1;
      end else if (byte_i == PFX_REL) begin
        rel_pend_d = 1'b1;
      end else begin
        vld_d      = 1'b1;
        evt_d.code = byte_i;
        evt_d.rel  = rel_pend_q;
        evt_d.ext  = ext_pend_q;
        ext_pend_d = 1'b0;
        rel_pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_pend_q <= 1'b0;
      rel_pend_q <= 1'b0;
      vld_q      <= 1'b0;
      evt_q      <= '0;
    end else begin
      ext_pend_q <= ext_pend_d;
      rel_pend_q <= rel_pend_d;
      vld_q      <= vld_d;
      evt_q      <= evt_d;
    end
  end

  assign evt_vld_o = vld_q;
  assign evt_o     = evt_q;

  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && (byte_i == PFX_EXT || byte_i == PFX_REL)) |=> !vld_q); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R12
endmodule

// File: rtl/ps2_keyrx.sv
module ps2_keyrx
  import ps2_keyrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_rel_o,
  output logic       key_ext_o,
  output logic       frame_err_o
);
  logic [1:0] rst_sr_q;
  logic       rst_int_n;
  logic       fall, dat;
  logic       byte_vld;
  logic [7:0] byte_val;
  key_evt_t   evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_int_n = rst_sr_q[1];

  ps2_line_sync #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_sync (
    .clk(clk), .rst_n(rst_int_n), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .fall_o(fall), .dat_o(dat)
  );

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_rx (
    .clk(clk), .rst_n(rst_int_n), .fall_i(fall), .dat_i(dat),
    .byte_vld_o(byte_vld), .byte_o(byte_val), .err_o(frame_err_o)
  );

  ps2_key_decode i_dec (
    .clk(clk), .rst_n(rst_int_n), .byte_vld_i(byte_vld), .byte_i(byte_val),
    .evt_vld_o(key_valid_o), .evt_o(evt)
  );

  assign key_code_o = evt.code;
  assign key_rel_o  = evt.rel;
  assign key_ext_o  = evt.ext;

  AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(key_valid_o && frame_err_o)); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!key_valid_o && !frame_err_o)); // R11
endmodule

// File: tb/test_ps2_keyrx.sv
module test_ps2_keyrx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;
  localparam int TMO        = 400;

  typedef struct {
    logic [7:0] code;
    logic       rel;
    logic       ext;
    logic       err;
    string      tag;
  } exp_t;

  logic clk, rst_n, kclk, kdat;
  logic key_valid, key_rel, key_ext, frame_err;
  logic [7:0] key_code;
  int checks, fails;
  bit run;
  logic prev_valid;
  exp_t sb[$];

  ps2_keyrx #(.TIMEOUT_CYC(TMO)) i_ps2_keyrx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(kclk), .ps2_dat_i(kdat),
    .key_valid_o(key_valid), .key_code_o(key_code), .key_rel_o(key_rel),
    .key_ext_o(key_ext), .frame_err_o(frame_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_key(input logic [7:0] c, input logic r, input logic e, input string t);
    exp_t x;
    x.code = c; x.rel = r; x.ext = e; x.err = 1'b0; x.tag = t;
    sb.push_back(x);
  endtask

  task automatic expect_err(input string t);
    exp_t x;
    x.code = 8'h00; x.rel = 1'b0; x.ext = 1'b0; x.err = 1'b1; x.tag = t;
    sb.push_back(x);
  endtask

  // stop_at < 11 ends the frame early; glitch_at inserts a short clock pulse
  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                      input int glitch_at, input int stop_at);
    logic [10:0] f;
    f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      if (i == stop_at) break;
      kdat = f[i];
      if (i == glitch_at) begin
        repeat (5) @(posedge clk);
        kclk = 1'b0;
        repeat (2) @(posedge clk);
        kclk = 1'b1;
        repeat (HALF - 7) @(posedge clk);
      end else begin
        repeat (HALF) @(posedge clk);
      end
      kclk = 1'b0;
      repeat (HALF) @(posedge clk);
      kclk = 1'b1;
    end
    repeat (HALF) @(posedge clk);
    kdat = 1'b1;
    repeat (2 * HALF) @(posedge clk);
  endtask

  task automatic send_ok(input logic [7:0] b);
    send(b, 1'b0, 1'b0, -1, 11);
  endtask

  always @(negedge clk) begin
    if (run) begin
      if (key_valid || frame_err) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL unexpected output: actual valid=%b err=%b code=%h expected nothing",
                   key_valid, frame_err, key_code);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.err) begin
            if (!(frame_err && !key_valid)) begin
              fails++;
              $display("FAIL %s: actual valid=%b err=%b expected frame error",
                       e.tag, key_valid, frame_err);
            end
          end else if (!key_valid || frame_err || prev_valid || key_code !== e.code ||
                       key_rel !== e.rel || key_ext !== e.ext) begin
            fails++;
            $display("FAIL %s: actual v=%b err=%b prevv=%b code=%h rel=%b ext=%b expected code=%h rel=%b ext=%b (R12 single pulse)",
                     e.tag, key_valid, frame_err, prev_valid, key_code, key_rel, key_ext,
                     e.code, e.rel, e.ext);
          end
        end
      end
    end
    prev_valid = key_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still going, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; run = 1'b0; prev_valid = 1'b0;
    rst_n = 1'b0; kclk = 1'b1; kdat = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;
    if (key_valid !== 1'b0 || frame_err !== 1'b0) begin
      fails++;
      $display("FAIL R11: actual valid=%b err=%b expected 0 0", key_valid, frame_err);
    end
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    run = 1'b1;

    expect_key(8'h1C, 1'b0, 1'b0, "R4");  send_ok(8'h1C);
    expect_key(8'h81, 1'b0, 1'b0, "R1");  send_ok(8'h81);
    expect_key(8'h1C, 1'b1, 1'b0, "R5");  send_ok(8'hF0); send_ok(8'h1C);
    expect_key(8'h75, 1'b0, 1'b1, "R6");  send_ok(8'hE0); send_ok(8'h75);
    expect_key(8'h75, 1'b1, 1'b1, "R7");  send_ok(8'hE0); send_ok(8'hF0); send_ok(8'h75);
    expect_key(8'h29, 1'b0, 1'b0, "R8");  send_ok(8'h29);
    expect_err("R3");                     send(8'h33, 1'b1, 1'b0, -1, 11);
    expect_key(8'h33, 1'b0, 1'b0, "R3");  send_ok(8'h33);
    expect_err("R2");                     send(8'h44, 1'b0, 1'b1, -1, 11);
    kclk = 1'b0;
    repeat (1000) @(posedge clk);
    kclk = 1'b1;
    repeat (50) @(posedge clk);
    expect_key(8'h5A, 1'b0, 1'b0, "R9");  send_ok(8'h5A);
    expect_key(8'h66, 1'b0, 1'b0, "R9");  send(8'h66, 1'b0, 1'b0, 4, 11);
    send(8'hA5, 1'b0, 1'b0, -1, 5);
    repeat (TMO + 200) @(posedge clk);
    expect_key(8'h1B, 1'b0, 1'b0, "R10"); send_ok(8'h1B);
    expect_key(8'h4D, 1'b0, 1'b0, "R8");  send_ok(8'h4D);

    repeat (200) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d results missing, expected 0", sb[0].tag, sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule